// File: doc/BRIEF.md
# Display Pixel Output Sequencer

This block turns a decoded picture held as 4:2:0 samples into a 4:2:2 component stream for display logic. The picture is read through a line-buffer style port with combinational read. For each output pixel pair the block presents a line index, a chroma line index and a group index. The memory returns the two luma samples and the Cb/Cr pair for that group. Every chroma line serves two consecutive luma lines, which gives the vertical upsampling.

The display side paces the stream with a take strobe. Each sample carries a 4-bit type code: the low two bits name the component and the high two bits give the frame or field kind. Two output flags mark the last component of a row and of the picture. Two inputs let display logic cut a row or the picture short. The following are captured when a picture starts: the group count per row, the line count, the field kind and the byte/16-bit mode. An 8-bit general-purpose value is passed through a register.

Top module: `dps_pixel_seq`

## Requirements
- R1: After reset pix_avail, row_end and pic_end are low and gp_out is 0.
- R2: A picture begins only on start while idle: pix_avail goes high on the cycle after. While idle pix_avail stays low and pix_take, row_cut and pic_cut have no effect. A start during a picture is ignored, and the sequence continues unchanged.
- R3: In byte mode (cfg_wide=0) each group is sent as four beats in the order Y1, Cb, Y2, Cr. The beats carry type low bits 00, 10, 01, 11. The sample is in pix_data[7:0] and pix_data[15:8] is zero. Y1=luma_pair[15:8], Y2=luma_pair[7:0], Cb=chroma_pair[15:8], Cr=chroma_pair[7:0].
- R4: In 16-bit mode (cfg_wide=1) each group is sent as two beats. The first is {Y1,Cb} with type low bits 10. The second is {Y2,Cr} with type low bits 11. Y is in the upper byte.
- R5: pix_type[3:2] equals the cfg_field value captured at start (00 progressive, 10 top field, 11 bottom field).
- R6: While pix_avail is high and pix_take is low, pix_data and pix_type hold their values. A beat is consumed only on a rising edge with pix_take high.
- R7: row_end is high exactly on the last beat of group cfg_groups-1 of a line.
- R8: pic_end is high exactly on the last beat of the last group of line cfg_lines-1. Once that beat is taken the block is idle.
- R9: rd_chroma_line equals rd_line/2, so each chroma line is reused for two luma lines.
- R10: row_cut seen with pix_take on any beat of a group moves the scan to group 0 of the next line once the group's last beat is taken. On a group that already ends its row it has no extra effect.
- R11: pic_cut seen with pix_take on any beat of a group makes the block idle once the group's last beat is taken.
- R12: gp_out equals gp_cfg delayed by one clock.
- R13: Every picture starts at line 0, group 0, beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a picture when idle |
| cfg_groups | input | COL_W | Pixel pairs per row (at least 1) |
| cfg_lines | input | LINE_W | Lines per picture (at least 1) |
| cfg_field | input | 2 | Frame/field kind for type high bits |
| cfg_wide | input | 1 | 1 selects 16-bit mode |
| gp_cfg | input | 8 | General-purpose value |
| rd_line | output | LINE_W | Luma line being read |
| rd_chroma_line | output | LINE_W | Chroma line being read |
| rd_group | output | COL_W | Pixel pair index in the line |
| luma_pair | input | 16 | {Y1,Y2} at rd_line/rd_group |
| chroma_pair | input | 16 | {Cb,Cr} at rd_chroma_line/rd_group |
| pix_data | output | 16 | Output sample(s) |
| pix_type | output | 4 | {field kind, component} |
| pix_avail | output | 1 | Valid sample on pix_data |
| pix_take | input | 1 | Display consumes the beat at this edge |
| row_end | output | 1 | Last beat of a row |
| pic_end | output | 1 | Last beat of the picture |
| row_cut | input | 1 | End the row after this group |
| pic_cut | input | 1 | End the picture after this group |
| gp_out | output | 8 | Registered general-purpose value |

## Verification
The bench sweeps whole pictures in both modes and for several row and line counts, including one-group rows and one-line pictures, with stalls of varying length. A design that mixed up beat order or type codes would fail the data checks. So would one that shifted data during a stall or read chroma from the wrong line. The flag checks at the ends of rows and pictures catch an off-by-one row or line count. An early row cut given on a middle beat must not lose the rest of the group. A cut on a row that already ends must not skip a line, which a design that advanced twice would do. A picture cut must leave the block idle, and a start during a picture must not restart it.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic [1:0] {
      COMP_Y1 = 2'b00,
      COMP_Y2 = 2'b01,
      COMP_CB = 2'b10,
      COMP_CR = 2'b11
   } comp_e;

   localparam int unsigned PHASE_W     = 2;
   localparam int unsigned BYTE_BEATS  = 4;
   localparam int unsigned WIDE_BEATS  = 2;
endpackage

// File: rtl/dps_phase_ctr.sv
module dps_phase_ctr
   import dps_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy,
   input  logic               wide,
   input  logic               take,
   output logic [PHASE_W-1:0] phase,
   output logic               last
);
   localparam logic [PHASE_W-1:0] LAST_BYTE = PHASE_W'(BYTE_BEATS - 1);
   localparam logic [PHASE_W-1:0] LAST_WIDE = PHASE_W'(WIDE_BEATS - 1);

   assign last = (phase == (wide ? LAST_WIDE : LAST_BYTE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (!busy) begin
         phase <= '0;
      end else if (take) begin
         phase <= last ? '0 : phase + 1'b1;
      end
   end
endmodule

// File: rtl/dps_scan_ctr.sv
module dps_scan_ctr #(
   parameter int unsigned COL_W  = 10,
   parameter int unsigned LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              take,
   input  logic              last_beat,
   input  logic              row_cut,
   input  logic              pic_cut,
   input  logic [COL_W-1:0]  groups,
   input  logic [LINE_W-1:0] lines,
   output logic              busy,
   output logic [LINE_W-1:0] line,
   output logic [COL_W-1:0]  col,
   output logic              row_end,
   output logic              pic_end
);
   logic row_pend, pic_pend;
   logic end_row, end_pic;

   assign row_end = busy && last_beat && (col == groups - 1'b1);
   assign pic_end = row_end && (line == lines - 1'b1);
   assign end_row = row_end || row_pend || row_cut;
   assign end_pic = pic_end || pic_pend || pic_cut ||
                    (end_row && (line == lines - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         line     <= '0;
         col      <= '0;
         row_pend <= 1'b0;
         pic_pend <= 1'b0;
      end else if (!busy) begin
         row_pend <= 1'b0;
         pic_pend <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            line <= '0;
            col  <= '0;
         end
      end else if (take) begin
         if (!last_beat) begin
            row_pend <= row_pend | row_cut;
            pic_pend <= pic_pend | pic_cut;
         end else begin
            row_pend <= 1'b0;
            pic_pend <= 1'b0;
            if (end_pic) begin
               busy <= 1'b0;
            end else if (end_row) begin
               col  <= '0;
               line <= line + 1'b1;
            end else begin
               col <= col + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dps_comp_mux.sv
module dps_comp_mux
   import dps_pkg::*;
#(
   parameter bit SUPPORT_WIDE = 1'b1
) (
   input  logic [PHASE_W-1:0] phase,
   input  logic               wide,
   input  logic [15:0]        luma_pair,
   input  logic [15:0]        chroma_pair,
   output logic [15:0]        data,
   output comp_e              comp
);
   logic [15:0] byte_data;
   comp_e       byte_comp;

   always_comb begin
      unique case (phase)
         2'd0:    begin byte_data = {8'h00, luma_pair[15:8]};   byte_comp = COMP_Y1; end
         2'd1:    begin byte_data = {8'h00, chroma_pair[15:8]}; byte_comp = COMP_CB; end
         2'd2:    begin byte_data = {8'h00, luma_pair[7:0]};    byte_comp = COMP_Y2; end
         default: begin byte_data = {8'h00, chroma_pair[7:0]};  byte_comp = COMP_CR; end
      endcase
   end

   generate
      if (SUPPORT_WIDE) begin : g_wide
         always_comb begin
            if (wide && phase[0]) begin
               data = {luma_pair[7:0], chroma_pair[7:0]};
               comp = COMP_CR;
            end else if (wide) begin
               data = {luma_pair[15:8], chroma_pair[15:8]};
               comp = COMP_CB;
            end else begin
               data = byte_data;
               comp = byte_comp;
            end
         end
      end else begin : g_byte_only
         assign data = byte_data;
         assign comp = byte_comp;
      end
   endgenerate
endmodule

// File: rtl/dps_pixel_seq.sv
module dps_pixel_seq
   import dps_pkg::*;
#(
   parameter int unsigned COL_W        = 10,
   parameter int unsigned LINE_W       = 10,
   parameter bit          SUPPORT_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [COL_W-1:0]  cfg_groups,
   input  logic [LINE_W-1:0] cfg_lines,
   input  logic [1:0]        cfg_field,
   input  logic              cfg_wide,
   input  logic [7:0]        gp_cfg,
   output logic [LINE_W-1:0] rd_line,
   output logic [LINE_W-1:0] rd_chroma_line,
   output logic [COL_W-1:0]  rd_group,
   input  logic [15:0]       luma_pair,
   input  logic [15:0]       chroma_pair,
   output logic [15:0]       pix_data,
   output logic [3:0]        pix_type,
   output logic              pix_avail,
   input  logic              pix_take,
   output logic              row_end,
   output logic              pic_end,
   input  logic              row_cut,
   input  logic              pic_cut,
   output logic [7:0]        gp_out
);
   generate
      if (COL_W < 1 || COL_W > 16) begin : g_bad_col
         $error("dps_pixel_seq: COL_W out of range");
      end
      if (LINE_W < 2 || LINE_W > 16) begin : g_bad_line
         $error("dps_pixel_seq: LINE_W out of range");
      end
   endgenerate

   logic [COL_W-1:0]   r_groups;
   logic [LINE_W-1:0]  r_lines;
   logic [1:0]         r_field;
   logic               r_wide;
   logic               busy, take, last_beat;
   logic [PHASE_W-1:0] phase;
   logic [LINE_W-1:0]  line;
   comp_e              comp;

   assign take = busy && pix_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_groups <= '0;
         r_lines  <= '0;
         r_field  <= '0;
         r_wide   <= 1'b0;
         gp_out   <= '0;
      end else begin
         gp_out <= gp_cfg;
         if (start && !busy) begin
            r_groups <= cfg_groups;
            r_lines  <= cfg_lines;
            r_field  <= cfg_field;
            r_wide   <= SUPPORT_WIDE ? cfg_wide : 1'b0;
         end
      end
   end

   dps_phase_ctr u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (busy),
      .wide  (r_wide),
      .take  (take),
      .phase (phase),
      .last  (last_beat)
   );

   dps_scan_ctr #(.COL_W(COL_W), .LINE_W(LINE_W)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .take      (take),
      .last_beat (last_beat),
      .row_cut   (row_cut),
      .pic_cut   (pic_cut),
      .groups    (r_groups),
      .lines     (r_lines),
      .busy      (busy),
      .line      (line),
      .col       (rd_group),
      .row_end   (row_end),
      .pic_end   (pic_end)
   );

   dps_comp_mux #(.SUPPORT_WIDE(SUPPORT_WIDE)) u_mux (
      .phase       (phase),
      .wide        (r_wide),
      .luma_pair   (luma_pair),
      .chroma_pair (chroma_pair),
      .data        (pix_data),
      .comp        (comp)
   );

   assign rd_line        = line;
   assign rd_chroma_line = line >> 1;
   assign pix_type       = {r_field, comp};
   assign pix_avail      = busy;
endmodule

// File: rtl/dps_pixel_seq_chk.sv
module dps_pixel_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic [15:0] pix_data,
   input logic [3:0]  pix_type,
   input logic        pix_avail,
   input logic        pix_take,
   input logic        row_end,
   input logic        pic_end,
   input logic [7:0]  gp_cfg,
   input logic [7:0]  gp_out
);
   // R2: idle without start stays idle
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pix_avail && !start) |=> !pix_avail);
   // R6: an untaken beat is held
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_avail && !pix_take) |=> (pix_avail && $stable(pix_data) && $stable(pix_type)));
   // R7: row flag only on a live beat
   p_row_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      row_end |-> pix_avail);
   // R8: picture end implies row end, then idle after take
   p_pic_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pic_end |-> row_end);
   p_pic_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pic_end && pix_take) |=> !pix_avail);
   // R12: general output follows its register
   p_gp_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (gp_out == $past(gp_cfg)));
endmodule

bind dps_pixel_seq dps_pixel_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .pix_data  (pix_data),
   .pix_type  (pix_type),
   .pix_avail (pix_avail),
   .pix_take  (pix_take),
   .row_end   (row_end),
   .pic_end   (pic_end),
   .gp_cfg    (gp_cfg),
   .gp_out    (gp_out)
);

// File: tb/tb_dps_pixel_seq.sv
module tb_dps_pixel_seq;
   localparam int COL_W  = 10;
   localparam int LINE_W = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [COL_W-1:0]  cfg_groups = '0;
   logic [LINE_W-1:0] cfg_lines = '0;
   logic [1:0]        cfg_field = '0;
   logic              cfg_wide = 1'b0;
   logic [7:0]        gp_cfg = '0;
   logic [LINE_W-1:0] rd_line, rd_chroma_line;
   logic [COL_W-1:0]  rd_group;
   logic [15:0]       luma_pair, chroma_pair, pix_data;
   logic [3:0]        pix_type;
   logic              pix_avail, row_end, pic_end;
   logic              pix_take = 1'b0, row_cut = 1'b0, pic_cut = 1'b0;
   logic [7:0]        gp_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] ypix(int ln, int cl, int k);
      return 8'(ln * 37 + cl * 11 + k * 5 + 1);
   endfunction
   function automatic logic [7:0] cpix(int cln, int cl, int k);
      return 8'(cln * 53 + cl * 7 + k * 3 + 128);
   endfunction

   assign luma_pair   = {ypix(int'(rd_line), int'(rd_group), 0), ypix(int'(rd_line), int'(rd_group), 1)};
   assign chroma_pair = {cpix(int'(rd_chroma_line), int'(rd_group), 0), cpix(int'(rd_chroma_line), int'(rd_group), 1)};

   dps_pixel_seq #(.COL_W(COL_W), .LINE_W(LINE_W)) dut (.*);

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Checks one beat (with hold cycles first) then takes it on the next edge.
   task automatic beat(int ln, int cl, int ph, bit wide, logic [1:0] fld,
                       bit rflag, bit pflag, int stall, bit rc, bit pc);
      logic [15:0] ed;
      logic [1:0]  ec;
      if (wide) begin
         ed = (ph == 0) ? {ypix(ln, cl, 0), cpix(ln / 2, cl, 0)} : {ypix(ln, cl, 1), cpix(ln / 2, cl, 1)};
         ec = (ph == 0) ? 2'b10 : 2'b11;
      end else begin
         case (ph)
            0: begin ed = {8'h00, ypix(ln, cl, 0)};     ec = 2'b00; end
            1: begin ed = {8'h00, cpix(ln / 2, cl, 0)}; ec = 2'b10; end
            2: begin ed = {8'h00, ypix(ln, cl, 1)};     ec = 2'b01; end
            default: begin ed = {8'h00, cpix(ln / 2, cl, 1)}; ec = 2'b11; end
         endcase
      end
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         pix_take = 1'b0; row_cut = 1'b0; pic_cut = 1'b0;
         chk(pix_avail && pix_data == ed && pix_type[1:0] == ec, "R6 hold", {pix_data, pix_type}, {ed, 2'b00, ec});
      end
      @(negedge clk);
      chk(pix_avail, "R2 avail", pix_avail, 1);
      chk(pix_data == ed, wide ? "R4/R9 data" : "R3/R9 data", pix_data, ed);
      chk(pix_type[1:0] == ec, wide ? "R4 type" : "R3 type", pix_type[1:0], ec);
      chk(pix_type[3:2] == fld, "R5 field", pix_type[3:2], fld);
      chk(row_end == rflag, "R7 row_end", row_end, rflag);
      chk(pic_end == pflag, "R8 pic_end", pic_end, pflag);
      pix_take = 1'b1; row_cut = rc; pic_cut = pc;
   endtask

   task automatic go(int g, int v, bit wide, logic [1:0] fld);
      @(negedge clk);
      pix_take = 1'b0; row_cut = 1'b0; pic_cut = 1'b0;
      cfg_groups = COL_W'(g); cfg_lines = LINE_W'(v); cfg_wide = wide; cfg_field = fld;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic expect_idle(string tag);
      @(negedge clk);
      pix_take = 1'b0; row_cut = 1'b0; pic_cut = 1'b0;
      chk(!pix_avail, tag, pix_avail, 0);
   endtask

   task automatic sweep(int g, int v, bit wide, logic [1:0] fld, int seed);
      int nb;
      nb = wide ? 2 : 4;
      go(g, v, wide, fld);
      for (int ln = 0; ln < v; ln++)
         for (int cl = 0; cl < g; cl++)
            for (int ph = 0; ph < nb; ph++)
               beat(ln, cl, ph, wide, fld, ph == nb - 1 && cl == g - 1,
                    ph == nb - 1 && cl == g - 1 && ln == v - 1,
                    (ln + cl + ph + seed) % 3, 1'b0, 1'b0);
      expect_idle("R8 idle after picture");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!pix_avail && !row_end && !pic_end && gp_out == 8'h00, "R1 reset", {pix_avail, row_end, pic_end, gp_out}, 0);
      rst_n = 1'b1;

      // R2: take and cuts while idle have no effect
      @(negedge clk);
      pix_take = 1'b1; row_cut = 1'b1; pic_cut = 1'b1;
      repeat (3) @(negedge clk);
      chk(!pix_avail, "R2 idle ignores take", pix_avail, 0);
      pix_take = 1'b0; row_cut = 1'b0; pic_cut = 1'b0;

      // R12
      gp_cfg = 8'hA5;
      @(negedge clk);
      chk(gp_out == 8'hA5, "R12 gp_out", gp_out, 8'hA5);
      gp_cfg = 8'h3C;
      @(negedge clk);
      chk(gp_out == 8'h3C, "R12 gp_out", gp_out, 8'h3C);

      // Sweeps R3..R9, R13
      sweep(3, 4, 1'b0, 2'b00, 0);
      sweep(3, 4, 1'b1, 2'b10, 1);
      sweep(1, 1, 1'b0, 2'b11, 2);
      sweep(1, 3, 1'b1, 2'b00, 0);
      sweep(4, 1, 1'b0, 2'b10, 1);
      sweep(2, 5, 1'b1, 2'b11, 2);

      // R10/R11 early cuts and R2 start while busy, G=3, V=3, byte mode
      go(3, 3, 1'b0, 2'b00);
      beat(0, 0, 0, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0);
      beat(0, 0, 1, 1'b0, 2'b00, 0, 0, 1, 1'b1, 1'b0);   // R10 cut on Cb beat
      beat(0, 0, 2, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0);
      beat(0, 0, 3, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0);
      for (int cl = 0; cl < 3; cl++)
         for (int ph = 0; ph < 4; ph++) begin
            if (cl == 1 && ph == 1) start = 1'b1;          // R2 start while busy
            beat(1, cl, ph, 1'b0, 2'b00, ph == 3 && cl == 2, 1'b0, ph % 2, ph == 3 && cl == 2, 1'b0);
            start = 1'b0;
         end
      // R10: cut on an ending row must not skip line 2
      beat(2, 0, 0, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b1);   // R11 cut on first beat
      beat(2, 0, 1, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0);
      beat(2, 0, 2, 1'b0, 2'b00, 0, 0, 2, 1'b0, 1'b0);
      beat(2, 0, 3, 1'b0, 2'b00, 0, 0, 0, 1'b0, 1'b0);
      expect_idle("R11 idle after picture cut");

      // R11 in wide mode, cut on last beat of middle group; then R13 restart
      go(3, 2, 1'b1, 2'b10);
      beat(0, 0, 0, 1'b1, 2'b10, 0, 0, 0, 1'b0, 1'b0);
      beat(0, 0, 1, 1'b1, 2'b10, 0, 0, 0, 1'b0, 1'b0);
      beat(0, 1, 0, 1'b1, 2'b10, 0, 0, 1, 1'b0, 1'b0);
      beat(0, 1, 1, 1'b1, 2'b10, 0, 0, 0, 1'b0, 1'b1);
      expect_idle("R11 idle after wide cut");
      go(3, 2, 1'b1, 2'b10);
      beat(0, 0, 0, 1'b1, 2'b10, 0, 0, 0, 1'b0, 1'b0);   // R13 restart at origin
      beat(0, 0, 1, 1'b1, 2'b10, 0, 0, 0, 1'b0, 1'b1);
      expect_idle("R11 idle after cut");

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule